// File: doc/BRIEF.md
# Page-Mapped Flash Translation Controller

This block sits between a host that reads and writes logical pages and a behavioural model of a NAND flash array. The host sees a flat space of logical pages; the block maps each one to a physical page through an on-chip table. A physical page is free, valid or stale. Every write is placed out of place on a free page. The write reads the old contents into a holding register, merges the new bytes under a byte mask, and programs the result to a fresh page. The page it replaces becomes stale.

Space is reclaimed by garbage collection. It starts when the number of free pages falls below one block. It picks the non-active block that holds the most stale pages; on a tie the lowest block index wins. It copies every still-valid page of that block to free pages and remaps them, then erases the whole block. While collection runs the block holds the host off by keeping `reqReady` low. A read of a logical page that was never written does not touch the array. It returns all ones and raises a flag.

Top module: `flash_xlate`

## Requirements
- R1: After reset every physical page is free and no logical page is mapped. `reqReady` is high, and `rspValid` and `gcBusy` are low.
- R2: The array is programmed only at a page that is free, meaning erased and not programmed since.
- R3: A read returns the whole page most recently written to that logical address, however many overwrites came in between.
- R4: A write merges under `reqMask`: bit i selects data bits 8i+7..8i from `reqData`, otherwise the byte keeps its previous value, which is all ones if the page was never written. The write response carries the merged page.
- R5: A read of a never-written logical page returns all ones with `rspUnmapped` high. A read of a mapped page returns it with `rspUnmapped` low.
- R6: Collection starts only when fewer than one block's worth of pages are free, so exactly one block free starts none. `reqReady` stays low whenever `gcBusy` is high.
- R7: Collection preserves every valid logical page: all mapped pages read back their last data after any number of collections.
- R8: `rspValid` is a one-cycle pulse. It appears one clock after the accepting edge for a read and two clocks after it for a write.
- R9: The victim is the non-active block with the most stale pages, with the lowest index winning a tie. A collection keeps `gcBusy` high for pages-per-block + v + 1 cycles, where v is the victim's valid pages, and ends with the erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Request accepted on this edge when high with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLpa | input | LPA_W (6) | Logical page address |
| reqData | input | DATA_W (32) | Write data |
| reqMask | input | DATA_W/8 (4) | Byte enables for a write |
| rspValid | output | 1 | Response pulse |
| rspData | output | DATA_W (32) | Read data, or the merged page on a write |
| rspUnmapped | output | 1 | Read hit an unwritten logical page |
| gcBusy | output | 1 | Garbage collection in progress |

## Verification
The bench builds the block with 8 blocks of 8 pages, 32-bit pages and 48 logical pages. This leaves exactly two blocks of spare space, so the collection trigger is reached after a few dozen writes. A scripted fill drives the cases with a precise expected count: no collection at exactly one free block, a victim with no valid page (9 busy cycles), and a victim with one valid page relocated into a freshly allocated spare block (10 busy cycles). Random masked overwrites against a reference map then force many collections in a row.

// File: rtl/fx_pkg.sv
package fx_pkg;

  typedef enum logic [1:0] {
    PG_FREE  = 2'd0,
    PG_VALID = 2'd1,
    PG_STALE = 2'd2
  } pg_state_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_WR_LOAD,
    S_WR_PROG,
    S_GC_SCAN,
    S_GC_MOVE,
    S_GC_ERASE
  } fsm_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic loadOld;
    logic progHost;
    logic respondRead;
    logic latchVictim;
    logic loadVictim;
    logic progMove;
    logic stepIdx;
    logic eraseVictim;
  } dp_strobe_t;

endpackage

// File: rtl/fx_nand_model.sv
module fx_nand_model #(
  parameter int NUM_BLOCKS      = 8,
  parameter int PAGES_PER_BLOCK = 8,
  parameter int DATA_W          = 32
) (
  input  logic                                                 clk,
  input  logic                                                 rstN,
  input  logic [$clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLOCK)-1:0] rdAddr,
  output logic [DATA_W-1:0]                                    rdData,
  input  logic                                                 progEn,
  input  logic [$clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLOCK)-1:0] progAddr,
  input  logic [DATA_W-1:0]                                    progData,
  input  logic                                                 eraseEn,
  input  logic [$clog2(NUM_BLOCKS)-1:0]                        eraseBlk
);
  localparam int NUM_PHYS = NUM_BLOCKS * PAGES_PER_BLOCK;
  localparam int PG_W     = $clog2(PAGES_PER_BLOCK);

  logic [DATA_W-1:0] mem [NUM_PHYS];

  assign rdData = mem[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PHYS; i++) mem[i] <= '1;
    end else begin
      if (progEn) mem[progAddr] <= progData;
      if (eraseEn) begin
        for (int p = 0; p < PAGES_PER_BLOCK; p++) mem[{eraseBlk, PG_W'(p)}] <= '1;
      end
    end
  end
endmodule

// File: rtl/fx_datapath.sv
module fx_datapath
  import fx_pkg::*;
#(
  parameter int NUM_BLOCKS      = 8,
  parameter int PAGES_PER_BLOCK = 8,
  parameter int DATA_W          = 32,
  parameter int NUM_LOGICAL     = 48,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
  localparam int PPA_W = BLK_W + PG_W,
  localparam int LPA_W = $clog2(NUM_LOGICAL),
  localparam int BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        st,
  input  logic [LPA_W-1:0]  reqLpa,
  input  logic [DATA_W-1:0] reqData,
  input  logic [BYTES-1:0]  reqMask,
  output logic              gcNeeded,
  output logic              victimPageValid,
  output logic              lastIdx,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspUnmapped,
  output logic [PPA_W-1:0]  nandRdAddr,
  input  logic [DATA_W-1:0] nandRdData,
  output logic              nandProgEn,
  output logic [PPA_W-1:0]  nandProgAddr,
  output logic [DATA_W-1:0] nandProgData,
  output logic              nandEraseEn,
  output logic [BLK_W-1:0]  nandEraseBlk
);
  localparam int NUM_PHYS = NUM_BLOCKS * PAGES_PER_BLOCK;
  localparam int CNT_W    = $clog2(NUM_PHYS + 1);
  localparam logic [CNT_W-1:0] PPB_CNT  = CNT_W'(PAGES_PER_BLOCK);
  localparam logic [CNT_W-1:0] PHYS_CNT = CNT_W'(NUM_PHYS);

  // latched request
  logic [LPA_W-1:0]  lpaQ;
  logic [DATA_W-1:0] dataQ;
  logic [BYTES-1:0]  maskQ;

  // translation table, page states, owner tags
  logic              mapVld [NUM_LOGICAL];
  logic [PPA_W-1:0]  mapPpa [NUM_LOGICAL];
  pg_state_e         pState [NUM_PHYS];
  logic [LPA_W-1:0]  owner  [NUM_PHYS];

  logic [BLK_W-1:0]  activeBlk;
  logic [PG_W:0]     activeFill;
  logic [CNT_W-1:0]  freeCnt;
  logic [BLK_W-1:0]  victimQ;
  logic [PG_W-1:0]   idxQ;
  logic [DATA_W-1:0] bufQ;

  logic              curMapped;
  logic [PPA_W-1:0]  curPpa;
  logic [PPA_W-1:0]  victimPpa;
  logic [PPA_W-1:0]  allocPpa;
  logic              activeFull;
  logic [DATA_W-1:0] merged;

  logic [NUM_BLOCKS-1:0] blkAllFree;
  logic [PG_W:0]         blkStale [NUM_BLOCKS];
  logic [BLK_W-1:0]      spareBlk;
  logic [BLK_W-1:0]      victimSel;
  logic                  spareFound;
  logic [PG_W:0]         bestStale;

  assign curMapped  = mapVld[lpaQ];
  assign curPpa     = mapPpa[lpaQ];
  assign victimPpa  = {victimQ, idxQ};
  assign activeFull = activeFill[PG_W];
  assign allocPpa   = activeFull ? {spareBlk, PG_W'(0)} : {activeBlk, activeFill[PG_W-1:0]};

  // per-block occupancy summary
  always_comb begin
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      blkAllFree[b] = 1'b1;
      blkStale[b]   = '0;
      for (int p = 0; p < PAGES_PER_BLOCK; p++) begin
        if (pState[b*PAGES_PER_BLOCK + p] != PG_FREE)  blkAllFree[b] = 1'b0;
        if (pState[b*PAGES_PER_BLOCK + p] == PG_STALE) blkStale[b] = blkStale[b] + {{PG_W{1'b0}}, 1'b1};
      end
    end
  end

  // spare block: lowest erased non-active block; victim: most stale, lowest index on tie
  always_comb begin
    spareBlk   = '0;
    spareFound = 1'b0;
    victimSel  = '0;
    bestStale  = '0;
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      if (BLK_W'(b) != activeBlk) begin
        if (blkAllFree[b] && !spareFound) begin
          spareBlk   = BLK_W'(b);
          spareFound = 1'b1;
        end
        if (blkStale[b] > bestStale) begin
          bestStale = blkStale[b];
          victimSel = BLK_W'(b);
        end
      end
    end
  end

  // byte-masked merge of new data over the held old page
  for (genvar i = 0; i < BYTES; i++) begin : g_merge
    assign merged[8*i +: 8] = maskQ[i] ? dataQ[8*i +: 8] : bufQ[8*i +: 8];
  end

  assign gcNeeded        = freeCnt < PPB_CNT;
  assign victimPageValid = pState[victimPpa] == PG_VALID;
  assign lastIdx         = idxQ == PG_W'(PAGES_PER_BLOCK - 1);

  assign nandRdAddr   = st.loadVictim ? victimPpa : curPpa;
  assign nandProgEn   = st.progHost | st.progMove;
  assign nandProgAddr = allocPpa;
  assign nandProgData = st.progMove ? bufQ : merged;
  assign nandEraseEn  = st.eraseVictim;
  assign nandEraseBlk = victimQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < NUM_LOGICAL; l++) begin
        mapVld[l] <= 1'b0;
        mapPpa[l] <= '0;
      end
      for (int q = 0; q < NUM_PHYS; q++) begin
        pState[q] <= PG_FREE;
        owner[q]  <= '0;
      end
      lpaQ        <= '0;
      dataQ       <= '0;
      maskQ       <= '0;
      activeBlk   <= '0;
      activeFill  <= '0;
      freeCnt     <= PHYS_CNT;
      victimQ     <= '0;
      idxQ        <= '0;
      bufQ        <= '0;
      rspValid    <= 1'b0;
      rspData     <= '0;
      rspUnmapped <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      if (st.latchReq) begin
        lpaQ  <= reqLpa;
        dataQ <= reqData;
        maskQ <= reqMask;
      end
      if (st.loadOld) bufQ <= curMapped ? nandRdData : '1;
      if (st.respondRead) begin
        rspValid    <= 1'b1;
        rspUnmapped <= !curMapped;
        rspData     <= curMapped ? nandRdData : '1;
      end
      if (st.progHost) begin
        pState[allocPpa] <= PG_VALID;
        owner[allocPpa]  <= lpaQ;
        mapPpa[lpaQ]     <= allocPpa;
        mapVld[lpaQ]     <= 1'b1;
        if (curMapped) pState[curPpa] <= PG_STALE;
        rspValid    <= 1'b1;
        rspUnmapped <= 1'b0;
        rspData     <= merged;
      end
      if (st.latchVictim) begin
        victimQ <= victimSel;
        idxQ    <= '0;
      end
      if (st.loadVictim) bufQ <= nandRdData;
      if (st.progMove) begin
        pState[allocPpa]         <= PG_VALID;
        owner[allocPpa]          <= owner[victimPpa];
        mapPpa[owner[victimPpa]] <= allocPpa;
        pState[victimPpa]        <= PG_STALE;
      end
      if (st.stepIdx) idxQ <= idxQ + PG_W'(1);
      if (st.progHost | st.progMove) begin
        freeCnt <= freeCnt - CNT_W'(1);
        if (activeFull) begin
          activeBlk  <= spareBlk;
          activeFill <= (PG_W+1)'(1);
        end else begin
          activeFill <= activeFill + (PG_W+1)'(1);
        end
      end
      if (st.eraseVictim) begin
        for (int p = 0; p < PAGES_PER_BLOCK; p++) pState[{victimQ, PG_W'(p)}] <= PG_FREE;
        freeCnt <= freeCnt + PPB_CNT;
      end
    end
  end
endmodule

// File: rtl/fx_ctrl.sv
module fx_ctrl
  import fx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       gcNeeded,
  input  logic       victimPageValid,
  input  logic       lastIdx,
  output dp_strobe_t st,
  output logic       reqReady,
  output logic       gcBusy
);
  fsm_e state, nextState;

  always_comb begin
    st        = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (gcNeeded) begin
          st.latchVictim = 1'b1;
          nextState      = S_GC_SCAN;
        end else if (reqValid) begin
          st.latchReq = 1'b1;
          nextState   = reqWrite ? S_WR_LOAD : S_RD;
        end
      end
      S_RD: begin
        st.respondRead = 1'b1;
        nextState      = S_IDLE;
      end
      S_WR_LOAD: begin
        st.loadOld = 1'b1;
        nextState  = S_WR_PROG;
      end
      S_WR_PROG: begin
        st.progHost = 1'b1;
        nextState   = S_IDLE;
      end
      S_GC_SCAN: begin
        if (victimPageValid) begin
          st.loadVictim = 1'b1;
          nextState     = S_GC_MOVE;
        end else if (lastIdx) begin
          nextState = S_GC_ERASE;
        end else begin
          st.stepIdx = 1'b1;
        end
      end
      S_GC_MOVE: begin
        st.progMove = 1'b1;
        if (lastIdx) begin
          nextState = S_GC_ERASE;
        end else begin
          st.stepIdx = 1'b1;
          nextState  = S_GC_SCAN;
        end
      end
      S_GC_ERASE: begin
        st.eraseVictim = 1'b1;
        nextState      = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign reqReady = (state == S_IDLE) && !gcNeeded;
  assign gcBusy   = (state == S_GC_SCAN) || (state == S_GC_MOVE) || (state == S_GC_ERASE);
endmodule

// File: rtl/flash_xlate.sv
module flash_xlate
  import fx_pkg::*;
#(
  parameter int NUM_BLOCKS      = 8,
  parameter int PAGES_PER_BLOCK = 8,
  parameter int DATA_W          = 32,
  parameter int NUM_LOGICAL     = 48,
  localparam int LPA_W = $clog2(NUM_LOGICAL),
  localparam int BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [LPA_W-1:0]  reqLpa,
  input  logic [DATA_W-1:0] reqData,
  input  logic [BYTES-1:0]  reqMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspUnmapped,
  output logic              gcBusy
);
  localparam int BLK_W = $clog2(NUM_BLOCKS);
  localparam int PPA_W = BLK_W + $clog2(PAGES_PER_BLOCK);

  dp_strobe_t        strobes;
  logic              gcNeeded;
  logic              victimPageValid;
  logic              lastIdx;
  logic [PPA_W-1:0]  nandRdAddr;
  logic [DATA_W-1:0] nandRdData;
  logic              nandProgEn;
  logic [PPA_W-1:0]  nandProgAddr;
  logic [DATA_W-1:0] nandProgData;
  logic              nandEraseEn;
  logic [BLK_W-1:0]  nandEraseBlk;

  fx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .gcNeeded(gcNeeded), .victimPageValid(victimPageValid), .lastIdx(lastIdx),
    .st(strobes), .reqReady(reqReady), .gcBusy(gcBusy)
  );

  fx_datapath #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
    .DATA_W(DATA_W), .NUM_LOGICAL(NUM_LOGICAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(strobes),
    .reqLpa(reqLpa), .reqData(reqData), .reqMask(reqMask),
    .gcNeeded(gcNeeded), .victimPageValid(victimPageValid), .lastIdx(lastIdx),
    .rspValid(rspValid), .rspData(rspData), .rspUnmapped(rspUnmapped),
    .nandRdAddr(nandRdAddr), .nandRdData(nandRdData),
    .nandProgEn(nandProgEn), .nandProgAddr(nandProgAddr), .nandProgData(nandProgData),
    .nandEraseEn(nandEraseEn), .nandEraseBlk(nandEraseBlk)
  );

  fx_nand_model #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .DATA_W(DATA_W)
  ) u_nand (
    .clk(clk), .rstN(rstN), .rdAddr(nandRdAddr), .rdData(nandRdData),
    .progEn(nandProgEn), .progAddr(nandProgAddr), .progData(nandProgData),
    .eraseEn(nandEraseEn), .eraseBlk(nandEraseBlk)
  );
endmodule

// File: rtl/flash_xlate_checker.sv
module flash_xlate_checker #(
  parameter int NUM_BLOCKS      = 8,
  parameter int PAGES_PER_BLOCK = 8,
  parameter int DATA_W          = 32,
  localparam int BLK_W    = $clog2(NUM_BLOCKS),
  localparam int PG_W     = $clog2(PAGES_PER_BLOCK),
  localparam int NUM_PHYS = NUM_BLOCKS * PAGES_PER_BLOCK
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  progEn,
  input logic [BLK_W+PG_W-1:0] progAddr,
  input logic                  eraseEn,
  input logic [BLK_W-1:0]      eraseBlk,
  input logic                  gcBusy,
  input logic                  reqReady,
  input logic                  rspValid,
  input logic                  rspUnmapped,
  input logic [DATA_W-1:0]     rspData
);
  // independent record of erased pages, built from array commands only
  logic [NUM_PHYS-1:0] shadowFree;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowFree <= '1;
    end else begin
      if (progEn) shadowFree[progAddr] <= 1'b0;
      if (eraseEn) begin
        for (int p = 0; p < PAGES_PER_BLOCK; p++) shadowFree[{eraseBlk, PG_W'(p)}] <= 1'b1;
      end
    end
  end

  assert_prog_free_R2: assert property (@(posedge clk) disable iff (!rstN)
    progEn |-> shadowFree[progAddr]);

  assert_gc_trigger_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gcBusy) |-> ($countones(shadowFree) < PAGES_PER_BLOCK));

  assert_hold_host_R6: assert property (@(posedge clk) disable iff (!rstN)
    gcBusy |-> !reqReady);

  assert_unmapped_ones_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspUnmapped) |-> (rspData == '1));

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_erase_ends_gc_R9: assert property (@(posedge clk) disable iff (!rstN)
    eraseEn |=> !gcBusy);

  assert_erase_in_gc_R9: assert property (@(posedge clk) disable iff (!rstN)
    eraseEn |-> (gcBusy && !progEn));
endmodule

bind flash_xlate flash_xlate_checker #(
  .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .progEn(nandProgEn), .progAddr(nandProgAddr),
  .eraseEn(nandEraseEn), .eraseBlk(nandEraseBlk), .gcBusy(gcBusy),
  .reqReady(reqReady), .rspValid(rspValid), .rspUnmapped(rspUnmapped), .rspData(rspData)
);

// File: tb/flash_xlate_tb.sv
module flash_xlate_tb;
  localparam int NB = 8, PPB = 8, DW = 32, NL = 48;
  localparam int VW = 76;  // {wr, lpa[6], mask[4], data[32], exp[32], unm}

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [5:0]  reqLpa = '0;
  logic [31:0] reqData = '0;
  logic [3:0]  reqMask = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        rspUnmapped;
  logic        gcBusy;

  int checks = 0;
  int fails  = 0;

  logic [31:0] refMem [NL];
  logic        refVld [NL];

  always #4 clk = ~clk;

  flash_xlate #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .DATA_W(DW), .NUM_LOGICAL(NL)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqLpa(reqLpa), .reqData(reqData), .reqMask(reqMask), .rspValid(rspValid),
    .rspData(rspData), .rspUnmapped(rspUnmapped), .gcBusy(gcBusy)
  );

  // R3 R4 R5 R8 vectors, walked after a fresh reset
  localparam int NV = 12;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 6'd5,  4'h0, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1},
    {1'b1, 6'd5,  4'hF, 32'h1122_3344, 32'h1122_3344, 1'b0},
    {1'b0, 6'd5,  4'h0, 32'h0000_0000, 32'h1122_3344, 1'b0},
    {1'b1, 6'd5,  4'h1, 32'h0000_00AA, 32'h1122_33AA, 1'b0},
    {1'b0, 6'd5,  4'h0, 32'h0000_0000, 32'h1122_33AA, 1'b0},
    {1'b1, 6'd47, 4'h6, 32'h00BB_CC00, 32'hFFBB_CCFF, 1'b0},
    {1'b0, 6'd47, 4'h0, 32'h0000_0000, 32'hFFBB_CCFF, 1'b0},
    {1'b1, 6'd0,  4'hF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0},
    {1'b0, 6'd0,  4'h0, 32'h0000_0000, 32'hDEAD_BEEF, 1'b0},
    {1'b0, 6'd46, 4'h0, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1},
    {1'b1, 6'd5,  4'h8, 32'h9900_0000, 32'h9922_33AA, 1'b0},
    {1'b0, 6'd5,  4'h0, 32'h0000_0000, 32'h9922_33AA, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int l = 0; l < NL; l++) begin
      refVld[l] = 1'b0;
      refMem[l] = '1;
    end
  endtask

  task automatic doOp(input logic wr, input logic [5:0] lpa, input logic [3:0] mask,
                      input logic [31:0] data, output logic [31:0] rd,
                      output logic unm, output int lat);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqLpa   = lpa;
    reqMask  = mask;
    reqData  = data;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!rspValid) begin
      @(negedge clk);
      lat++;
    end
    rd  = rspData;
    unm = rspUnmapped;
  endtask

  task automatic hostWrite(input logic [5:0] lpa, input logic [3:0] mask, input logic [31:0] data);
    logic [31:0] exp;
    logic [31:0] rd;
    logic        unm;
    int          lat;
    exp = refMem[lpa];
    for (int b = 0; b < 4; b++) if (mask[b]) exp[8*b +: 8] = data[8*b +: 8];
    doOp(1'b1, lpa, mask, data, rd, unm, lat);
    check(rd == exp, "R4", "write merge", rd, exp);
    check(lat == 2, "R8", "write latency", 32'(lat), 32'd2);
    refMem[lpa] = exp;
    refVld[lpa] = 1'b1;
  endtask

  task automatic hostRead(input logic [5:0] lpa, input string req);
    logic [31:0] rd;
    logic        unm;
    int          lat;
    doOp(1'b0, lpa, 4'h0, 32'h0, rd, unm, lat);
    check(rd == refMem[lpa], req, "read data", rd, refMem[lpa]);
    check(unm == !refVld[lpa], "R5", "unmapped flag", 32'(unm), 32'(!refVld[lpa]));
    check(lat == 1, "R8", "read latency", 32'(lat), 32'd1);
  endtask

  task automatic countBusy(input int win, output int n);
    n = 0;
    repeat (win) begin
      @(negedge clk);
      if (gcBusy) n++;
      if (gcBusy && reqReady) check(1'b0, "R6", "ready during collection", 32'd1, 32'd0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic        unm;
    int          lat;
    int          busy;

    doReset();
    @(negedge clk);
    // R1: reset state at the ports
    check(reqReady == 1'b1, "R1", "reqReady after reset", 32'(reqReady), 32'd1);
    check(rspValid == 1'b0, "R1", "rspValid after reset", 32'(rspValid), 32'd0);
    check(gcBusy == 1'b0,   "R1", "gcBusy after reset",   32'(gcBusy),   32'd0);
    hostRead(6'd17, "R1");

    // vector table: R3 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      doOp(v[75], v[74:69], v[68:65], v[64:33], rd, unm, lat);
      check(rd == v[32:1], v[75] ? "R4" : "R3", "vector data", rd, v[32:1]);
      check(unm == v[0], "R5", "vector unmapped flag", 32'(unm), 32'(v[0]));
      check(lat == (v[75] ? 2 : 1), "R8", "vector latency", 32'(lat), v[75] ? 32'd2 : 32'd1);
    end

    // directed collection scenario
    doReset();
    for (int l = 0; l < NL; l++) hostWrite(6'(l), 4'hF, 32'h1000_0000 + 32'(l));
    for (int l = 0; l < 8; l++) hostWrite(6'(l), 4'hF, 32'h2000_0000 + 32'(l));
    countBusy(14, busy);
    check(busy == 0, "R6", "no collection at one block free", 32'(busy), 32'd0);
    hostWrite(6'd0, 4'hF, 32'h3000_0000);
    countBusy(30, busy);
    check(busy == 9, "R9", "busy cycles, victim with no valid page", 32'(busy), 32'd9);
    for (int l = 8; l < 15; l++) hostWrite(6'(l), 4'hF, 32'h4000_0000 + 32'(l));
    hostWrite(6'd16, 4'hF, 32'h5000_0016);
    countBusy(30, busy);
    check(busy == 10, "R9", "busy cycles, victim with one valid page", 32'(busy), 32'd10);
    for (int l = 0; l < NL; l++) hostRead(6'(l), "R7");

    // random overwrites forcing repeated collection
    for (int i = 0; i < 1500; i++) begin
      logic [5:0] lpa;
      lpa = 6'($urandom_range(NL - 1));
      if ($urandom_range(9) < 6) hostWrite(lpa, 4'($urandom_range(15)), $urandom);
      else                       hostRead(lpa, "R3");
    end
    // R7 and R2: every page intact after many collections, so no live page was overprogrammed
    for (int l = 0; l < NL; l++) hostRead(6'(l), "R7");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule